// File: doc/BRIEF.md
# Deterministic Test Pattern Generator for Two-Level AND-XOR Networks

This block drives the inputs of an easily testable two-level AND-XOR circuit during built-in self-test. It does not depend on the function the circuit computes. After a start request it emits a fixed sequence of `N + 6` vectors on one parallel bus. Each vector holds two control lines followed by `N` data inputs. No seed is loaded, and a synchronous reset is the only thing that prepares the generator.

The sequence has two phases. A small state machine first walks through six fixed control vectors. In each one the data lines are either all zeros or all ones. A one-flop-per-input shift chain then moves a single zero across the data lines, from the first input to the last, with both control lines low. Each vector is shown for exactly one clock and is marked by a valid strobe. A done flag then rises, and the bus stays frozen until the next reset. Response compaction and signature comparison belong to other blocks.

Top module: `xor_net_pattern_gen`

## Requirements
- R1: While reset is high and afterwards until a start is accepted, `valid_o` and `done_o` are 0 and `pat_o` is all zeros.
- R2: When `start_i` is sampled high by a clock edge in the idle state, vector 1 appears on `pat_o` after that same edge with `valid_o` high.
- R3: Bus layout: `pat_o[N+1]` is control line A, `pat_o[N]` is control line B, and `pat_o[k-1]` is data input k. Vectors 1 to 6, written as (A, B, data), are (0,0,zeros), (0,0,ones), (0,1,zeros), (0,1,ones), (1,0,zeros) and (1,1,ones), in that order.
- R4: Vectors 7 to N+6 have A = B = 0. In vector 6+k, data bit k-1 is 0 and every other data bit is 1.
- R5: `valid_o` is high for exactly N+6 consecutive clocks per run. Each vector is held for exactly one clock.
- R6: After the last vector, `valid_o` is 0 and `done_o` is 1. `pat_o` keeps the last vector and all outputs stay unchanged until reset.
- R7: `start_i` has no effect while a run is in progress or once `done_o` is high.
- R8: A reset in the middle of a run returns the block to the R1 state. A later start replays the sequence from vector 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin the sequence (accepted only in idle) |
| pat_o | output | N+2 | {control A, control B, data[N-1:0]} |
| valid_o | output | 1 | High for one clock per emitted vector |
| done_o | output | 1 | High after the final vector until reset |

## Verification
The hand-over from the sixth control vector to the first walking-zero vector is a key corner case. A chain that injects its zero one clock late would repeat an all-ones vector and lose input 1. A chain that injects it one clock early would skip a data position. The final vector is checked to carry its zero on the top data bit, followed by exactly one idle clock with done high. An off-by-one walk counter would emit N+5 or N+7 vectors or let the zero fall off the chain. Start pulses are sent in the middle of a run and after done, and a reset is applied mid-run. A generator that re-arms on start, or that does not clear its chain on reset, would then show vectors out of order.

// File: rtl/xpg_pkg.sv
package xpg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_V1,
    ST_V2,
    ST_V3,
    ST_V4,
    ST_V5,
    ST_V6,
    ST_WALK,
    ST_STOP
  } xpg_state_e;

  // {control A, control B, data fill value} for the six fixed vectors
  function automatic logic [2:0] ctrl_vec(input xpg_state_e st);
    case (st)
      ST_V1:   ctrl_vec = 3'b000;
      ST_V2:   ctrl_vec = 3'b001;
      ST_V3:   ctrl_vec = 3'b010;
      ST_V4:   ctrl_vec = 3'b011;
      ST_V5:   ctrl_vec = 3'b100;
      ST_V6:   ctrl_vec = 3'b111;
      default: ctrl_vec = 3'b000;
    endcase
  endfunction

  function automatic logic is_emit(input xpg_state_e st);
    is_emit = (st != ST_IDLE) && (st != ST_STOP);
  endfunction

endpackage

// File: rtl/xpg_ctrl.sv
module xpg_ctrl
  import xpg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  output xpg_state_e state_q_o,
  output xpg_state_e state_d_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  xpg_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_V1;
      ST_V1:   state_d = ST_V2;
      ST_V2:   state_d = ST_V3;
      ST_V3:   state_d = ST_V4;
      ST_V4:   state_d = ST_V5;
      ST_V5:   state_d = ST_V6;
      ST_V6: begin
        state_d = ST_WALK;
        idx_d   = '0;
      end
      ST_WALK: begin
        if (idx_q == LAST) state_d = ST_STOP;
        else               idx_d   = idx_q + 1'b1;
      end
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
endmodule

// File: rtl/xpg_walk_chain.sv
module xpg_walk_chain
  import xpg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  xpg_state_e   state_q_i,
  input  xpg_state_e   state_d_i,
  output logic [N-1:0] walk_d_o
);
  logic [N-1:0] walk_q, walk_d;
  logic         shift_en, inject;

  assign shift_en = (state_d_i == ST_WALK);
  // A zero enters stage 0 on the first walk step; ones follow it.
  assign inject   = (state_q_i == ST_WALK);

  generate
    for (genvar g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign walk_d[g] = shift_en ? inject : walk_q[g];
      end else begin : g_body
        assign walk_d[g] = shift_en ? walk_q[g-1] : walk_q[g];
      end
      always_ff @(posedge clk) begin
        if (rst) walk_q[g] <= 1'b1;
        else     walk_q[g] <= walk_d[g];
      end
    end
  endgenerate

  assign walk_d_o = walk_d;
endmodule

// File: rtl/xpg_out_stage.sv
module xpg_out_stage
  import xpg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  xpg_state_e   state_d_i,
  input  logic [N-1:0] walk_d_i,
  output logic [N+1:0] pat_o,
  output logic         valid_o,
  output logic         done_o
);
  logic [N+1:0] pat_q;
  logic         valid_q, done_q;
  logic [2:0]   cv;

  assign cv = ctrl_vec(state_d_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= is_emit(state_d_i);
      done_q  <= (state_d_i == ST_STOP);
      case (state_d_i)
        ST_V1, ST_V2, ST_V3, ST_V4, ST_V5, ST_V6:
          pat_q <= {cv[2:1], {N{cv[0]}}};
        ST_WALK:
          pat_q <= {2'b00, walk_d_i};
        default:
          pat_q <= pat_q;
      endcase
    end
  end

  assign pat_o   = pat_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;
endmodule

// File: rtl/xor_net_pattern_gen.sv
module xor_net_pattern_gen
  import xpg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  output logic [N+1:0] pat_o,
  output logic         valid_o,
  output logic         done_o
);
  xpg_state_e   state_q, state_d;
  logic [N-1:0] walk_d;

  generate
    if (N < 2) begin : g_bad_width
      initial $display("xor_net_pattern_gen: N must be at least 2");
    end
  endgenerate

  xpg_ctrl #(.N(N)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .state_q_o (state_q),
    .state_d_o (state_d)
  );

  xpg_walk_chain #(.N(N)) chain_i (
    .clk       (clk),
    .rst       (rst),
    .state_q_i (state_q),
    .state_d_i (state_d),
    .walk_d_o  (walk_d)
  );

  xpg_out_stage #(.N(N)) out_i (
    .clk       (clk),
    .rst       (rst),
    .state_d_i (state_d),
    .walk_d_i  (walk_d),
    .pat_o     (pat_o),
    .valid_o   (valid_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/xpg_checker.sv
module xpg_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [N+1:0] pat_o,
  input logic         valid_o,
  input logic         done_o
);
  localparam int CW = $clog2(N + 8) + 1;
  localparam logic [CW-1:0] TOTAL = CW'(N + 6);

  logic [CW-1:0] vcnt_q;
  logic [N-1:0]  x;
  assign x = pat_o[N-1:0];

  always_ff @(posedge clk) begin
    if (rst)          vcnt_q <= '0;
    else if (valid_o) vcnt_q <= vcnt_q + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) && !rst |-> !valid_o && !done_o && (pat_o == '0));

  // R3
  ctrl_v5_to_v6_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && pat_o[N+1] && !pat_o[N] |=> valid_o && pat_o[N+1] && pat_o[N] && (&x));

  // R4
  walk_step_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && !pat_o[N+1] && !pat_o[N] && ($countones(x) == N - 1) && x[N-1]
    |=> valid_o && (x == {$past(pat_o[N-2:0]), 1'b1}));

  // R5
  vec_count_chk: assert property (@(posedge clk) disable iff (rst)
    vcnt_q <= TOTAL);

  // R5
  count_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> vcnt_q == TOTAL);

  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && valid_o));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o && !valid_o && $stable(pat_o));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && start_i && !(!pat_o[N+1] && !pat_o[N] && ($countones(x) == N - 1) && !x[N-1])
    |=> valid_o);
endmodule

bind xor_net_pattern_gen xpg_checker #(.N(N)) xpg_chk_i (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .pat_o   (pat_o),
  .valid_o (valid_o),
  .done_o  (done_o)
);

// File: tb/xor_net_pattern_gen_tb_top.sv
module xor_net_pattern_gen_tb_top;
  localparam int N      = 8;
  localparam int W      = N + 2;
  localparam int TOTAL  = N + 6;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] pat_o;
  logic         valid_o, done_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  xor_net_pattern_gen #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .pat_o(pat_o), .valid_o(valid_o), .done_o(done_o)
  );

  function automatic logic [W-1:0] exp_vec(input int k);
    logic [W-1:0] v;
    case (k)
      1: v = {2'b00, {N{1'b0}}};
      2: v = {2'b00, {N{1'b1}}};
      3: v = {2'b01, {N{1'b0}}};
      4: v = {2'b01, {N{1'b1}}};
      5: v = {2'b10, {N{1'b0}}};
      6: v = {2'b11, {N{1'b1}}};
      default: begin
        v = {2'b00, {N{1'b1}}};
        v[k-7] = 1'b0;
      end
    endcase
    return v;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start_i = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // start pulse at a negedge; vector 1 is visible at the next negedge
  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 pattern", pat_o, '0);
    chk("R1 valid/done", W'({valid_o, done_o}), W'(0));
    repeat (3) @(negedge clk);
    chk("R1 idle without start", W'({valid_o, done_o}), W'(0));
  endtask

  task automatic t_full_run(input bool_poke);
    do_reset();
    pulse_start();
    for (int k = 1; k <= TOTAL; k++) begin
      if (bool_poke && (k == 3 || k == 9)) start_i = 1'b1;  // R7 poke mid-run
      chk($sformatf("%s vector %0d", (k <= 6) ? "R3" : "R4", k), pat_o, exp_vec(k));
      chk($sformatf("R5 valid at vector %0d", k), W'({valid_o, done_o}), W'(2'b10));
      if (k == 1) chk("R2 first vector after start", pat_o, exp_vec(1));
      @(negedge clk);
      start_i = 1'b0;
    end
    chk("R6 done after last", W'({valid_o, done_o}), W'(2'b01));
    chk("R6 last vector held", pat_o, exp_vec(TOTAL));
  endtask

  task automatic t_after_done();
    start_i = 1'b1;
    repeat (4) @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R7 start after done ignored", W'({valid_o, done_o}), W'(2'b01));
    chk("R6 pattern frozen", pat_o, exp_vec(TOTAL));
  endtask

  task automatic t_abort();
    do_reset();
    pulse_start();
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 reset mid-run pattern", pat_o, '0);
    chk("R8 reset mid-run flags", W'({valid_o, done_o}), W'(0));
    @(negedge clk);
    pulse_start();
    for (int k = 1; k <= TOTAL; k++) begin
      chk($sformatf("R8 replay vector %0d", k), pat_o, exp_vec(k));
      @(negedge clk);
    end
    chk("R8 replay done", W'({valid_o, done_o}), W'(2'b01));
  endtask

  initial begin
    t_reset_state();
    t_full_run(1'b0);
    t_after_done();
    t_full_run(1'b1);
    t_abort();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule